// File: doc/BRIEF.md
# Replicated register steering unit

This block sits in front of a bank of register copies that all answer at one host address. The copies are arranged as `GROUPS` groups of `INSTS` copies each, and every copy holds its own value. A selector register picks one copy by group and instance number. The selector also carries a broadcast flag. When the flag is set, a host write to the shared address reaches every copy. When the flag is clear, the write reaches only the selected copy. Host reads of the shared address always come from the selected copy, whatever the broadcast flag says.

A static present mask, with one bit per copy, marks units that are fused off or powered down. A read steered to a missing copy completes and returns zero. A write to a missing copy is discarded, and a broadcast write passes over missing copies.

Two host agents share the selector. A read-to-acquire semaphore arbitrates between them: the selector accepts a write only from the agent that currently holds the semaphore. The host bus is a single-cycle register interface. Read data is combinational while `bus_re` is high, and every write and every side effect of a read takes place at the next rising clock edge.

Top module: `replicated_steer_unit`

## Requirements
- R1: After synchronous reset, the selector reads `0x80000000`: broadcast flag set, group 0, instance 0. Every copy reads zero, and the semaphore is free.
- R2: With the broadcast flag set, a write to the shared address (word address 1) stores the data in every present copy.
- R3: With the broadcast flag clear, a write to the shared address stores the data only in copy number `group*INSTS + instance`. Every other copy keeps its value.
- R4: A read of the shared address returns the value of the selected copy, whether the broadcast flag is set or clear.
- R5: A read of the shared address returns zero when the selected copy's bit in `present_mask` is 0.
- R6: A write, unicast or broadcast, leaves unchanged any copy whose present bit is 0 at the time of the write. This can be seen later by raising that bit and reading the copy.
- R7: The selector sits at word address 0 and has this layout: bit DW-1 is the broadcast flag, bits 15:8 are the group ID, and bits 7:0 are the instance ID. Only the low log2(GROUPS) and log2(INSTS) bits of the ID fields are kept. The unused bits are dropped on write and read back as zero.
- R8: The semaphore sits at word address 2. A read by any agent while the semaphore is free returns 1 and makes the reader its owner. A read by the owner returns 1. A read by the other agent while the semaphore is held returns 0 and changes nothing.
- R9: A write with data bit 0 = 1 from the owner frees the semaphore. Writes from the non-owner are ignored, and so are writes with bit 0 = 0. After a release, the next semaphore read by either agent acquires it.
- R10: A write to the selector takes effect only when the writing agent holds the semaphore. Otherwise the selector is unchanged.
- R11: A read of any other address returns zero, and `bus_rdata` is zero whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_agent | input | 1 | Which of the two host agents is making the access |
| bus_addr | input | AW | Word address of the access |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| present_mask | input | GROUPS*INSTS | One bit per copy; 1 means the copy exists and is powered |
| bus_rdata | output | DW | Read data, valid while `bus_re` is high |

## Verification
A behavioural model holds one value per copy, the selector fields and the semaphore state. Every read is checked against this model.

The directed sequence separates the four write cases: broadcast with all copies present, broadcast with holes in the mask, unicast to a present copy, and unicast to a missing copy. After each case a sweep over all selector settings reads every copy back, with the broadcast flag both set and clear. This shows that writes fan out, that reads never do, and that a missing copy is skipped rather than cleared.

The semaphore is driven through acquire, a contending read, release attempts from the non-owner and with a zero data bit, and hand-over. Each step is followed by a selector write from each agent, so the guard can be seen at the ports. A long run of mixed random accesses from both agents then changes the mask and mixes all address spaces.

// File: rtl/steer_pkg.sv
package steer_pkg;

    // Selector field placement. The host software decodes these positions.
    localparam int FIELD_W  = 8;
    localparam int INST_LSB = 0;
    localparam int GRP_LSB  = 8;

    // Word addresses of the three visible registers.
    localparam logic [15:0] ADR_SEL = 16'h0000;
    localparam logic [15:0] ADR_REP = 16'h0001;
    localparam logic [15:0] ADR_SEM = 16'h0002;

    typedef enum logic [1:0] {
        SP_SEL,
        SP_REP,
        SP_SEM,
        SP_NONE
    } space_e;

    typedef struct packed {
        logic               bcast;
        logic [FIELD_W-1:0] grp;
        logic [FIELD_W-1:0] inst;
    } sel_t;

    localparam sel_t SEL_RESET = '{bcast: 1'b1, grp: '0, inst: '0};

    function automatic space_e decode_space(input logic [15:0] a);
        space_e s;
        case (a)
            ADR_SEL: s = SP_SEL;
            ADR_REP: s = SP_REP;
            ADR_SEM: s = SP_SEM;
            default: s = SP_NONE;
        endcase
        return s;
    endfunction

    function automatic int lin_index(input int g, input int i, input int per_grp);
        return g * per_grp + i;
    endfunction

endpackage

// File: rtl/steer_sema.sv
module steer_sema (
    input  logic clk,
    input  logic rst,
    input  logic rd_hit,
    input  logic wr_hit,
    input  logic agent,
    input  logic rel_bit,
    output logic held,
    output logic owner,
    output logic grant,
    output logic rd_val
);
    logic held_q;
    logic owner_q;

    // The agent holds the semaphore right now.
    assign grant  = held_q && (owner_q == agent);
    // The value a read returns: 1 if the reader takes the semaphore or already owns it.
    assign rd_val = !held_q || grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= 1'b0;
            owner_q <= 1'b0;
        end else if (rd_hit && !held_q) begin
            held_q  <= 1'b1;
            owner_q <= agent;
        end else if (wr_hit && rel_bit && grant) begin
            held_q  <= 1'b0;
        end
    end

    assign held  = held_q;
    assign owner = owner_q;

endmodule

// File: rtl/steer_selector.sv
module steer_selector
    import steer_pkg::*;
#(
    parameter int DW = 32,
    parameter int GW = 1,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output sel_t          sel,
    output logic [DW-1:0] word
);
    sel_t sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SEL_RESET;
        end else if (wr_en) begin
            sel_q.bcast <= wdata[DW-1];
            sel_q.grp   <= FIELD_W'(wdata[GRP_LSB +: GW]);
            sel_q.inst  <= FIELD_W'(wdata[INST_LSB +: IW]);
        end
    end

    assign sel = sel_q;

    always_comb begin
        word                       = '0;
        word[DW-1]                 = sel_q.bcast;
        word[GRP_LSB +: FIELD_W]   = sel_q.grp;
        word[INST_LSB +: FIELD_W]  = sel_q.inst;
    end

    // Field bits beyond the configured widths are dropped on write.
    logic unused_wbits;
    assign unused_wbits = ^wdata;

endmodule

// File: rtl/steer_bank.sv
module steer_bank #(
    parameter int N    = 8,
    parameter int DW   = 32,
    parameter int IDXW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            bcast,
    input  logic [IDXW-1:0] idx,
    input  logic [DW-1:0]   wdata,
    input  logic [N-1:0]    present,
    output logic [DW-1:0]   rdata,
    output logic [N*DW-1:0] store_flat
);
    for (genvar k = 0; k < N; k++) begin : g_cell
        logic          hit;
        logic [DW-1:0] val_q;

        // Write enable for this copy: it must be present, and either the
        // write is a broadcast or the selector points at this copy.
        assign hit = wr_en && present[k] && (bcast || (idx == IDXW'(k)));

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (hit) begin
                val_q <= wdata;
            end
        end

        assign store_flat[k*DW +: DW] = val_q;
    end

    // A read always comes from the selected copy; a missing copy reads as zero.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < N; k++) begin
            if ((idx == IDXW'(k)) && present[k]) begin
                rdata = store_flat[k*DW +: DW];
            end
        end
    end

endmodule

// File: rtl/replicated_steer_unit.sv
module replicated_steer_unit
    import steer_pkg::*;
#(
    parameter int GROUPS = 2,
    parameter int INSTS  = 4,
    parameter int DW     = 32,
    parameter int AW     = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_agent,
    input  logic [AW-1:0]           bus_addr,
    input  logic                    bus_re,
    input  logic                    bus_we,
    input  logic [DW-1:0]           bus_wdata,
    input  logic [GROUPS*INSTS-1:0] present_mask,
    output logic [DW-1:0]           bus_rdata
);
    localparam int N    = GROUPS * INSTS;
    localparam int GW   = (GROUPS > 1) ? $clog2(GROUPS) : 1;
    localparam int IW   = (INSTS > 1) ? $clog2(INSTS) : 1;
    localparam int IDXW = (N > 1) ? $clog2(N) : 1;

    space_e           space;
    sel_t             sel;
    logic [DW-1:0]    sel_word;
    logic [DW-1:0]    rep_rdata;
    logic [IDXW-1:0]  rep_idx;
    logic [N*DW-1:0]  store_flat;
    logic             sem_held;
    logic             sem_owner;
    logic             sem_grant;
    logic             sem_rd_val;

    assign space = decode_space(16'(bus_addr));

    steer_sema u_sema (
        .clk     (clk),
        .rst     (rst),
        .rd_hit  (bus_re && (space == SP_SEM)),
        .wr_hit  (bus_we && (space == SP_SEM)),
        .agent   (bus_agent),
        .rel_bit (bus_wdata[0]),
        .held    (sem_held),
        .owner   (sem_owner),
        .grant   (sem_grant),
        .rd_val  (sem_rd_val)
    );

    steer_selector #(
        .DW (DW),
        .GW (GW),
        .IW (IW)
    ) u_sel (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_we && (space == SP_SEL) && sem_grant),
        .wdata (bus_wdata),
        .sel   (sel),
        .word  (sel_word)
    );

    assign rep_idx = IDXW'(lin_index(int'(sel.grp[GW-1:0]), int'(sel.inst[IW-1:0]), INSTS));

    steer_bank #(
        .N    (N),
        .DW   (DW),
        .IDXW (IDXW)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (bus_we && (space == SP_REP)),
        .bcast      (sel.bcast),
        .idx        (rep_idx),
        .wdata      (bus_wdata),
        .present    (present_mask),
        .rdata      (rep_rdata),
        .store_flat (store_flat)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            case (space)
                SP_SEL:  bus_rdata = sel_word;
                SP_REP:  bus_rdata = rep_rdata;
                SP_SEM:  bus_rdata = DW'(sem_rd_val);
                default: bus_rdata = '0;
            endcase
        end
    end

    // Upper ID bits are zero by construction of the selector.
    logic unused_sel;
    assign unused_sel = ^{sel.grp, sel.inst};

endmodule

// File: rtl/steer_chk.sv
module steer_chk
    import steer_pkg::*;
#(
    parameter int N    = 8,
    parameter int DW   = 32,
    parameter int IDXW = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_re,
    input logic            bus_we,
    input logic            bus_agent,
    input logic [DW-1:0]   bus_wdata,
    input logic [DW-1:0]   bus_rdata,
    input logic [N-1:0]    present_mask,
    input space_e          space,
    input logic [DW-1:0]   sel_word,
    input logic            sem_held,
    input logic            sem_owner,
    input logic [IDXW-1:0] rep_idx,
    input logic [N*DW-1:0] store_flat
);
    // R1: the first cycle out of reset shows the default selector.
    a_r1_reset_selector: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_word == (DW'(1) << (DW-1))));

    // R5: a read steered to a missing copy returns zero.
    a_r5_absent_read_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_re && (space == SP_REP) && !present_mask[rep_idx]) |-> (bus_rdata == '0));

    // R8: while the other agent holds the semaphore, a read of it returns zero.
    a_r8_sem_locked_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_re && (space == SP_SEM) && sem_held && (sem_owner != bus_agent)) |-> (bus_rdata == '0));

    // R9: a release by the owner frees the semaphore.
    a_r9_owner_release: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !bus_re && (space == SP_SEM) && bus_wdata[0] && sem_held && (sem_owner == bus_agent))
        |=> !sem_held);

    // R10: a selector write from an agent that does not hold the semaphore has no effect.
    a_r10_sel_guard: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (space == SP_SEL) && !(sem_held && (sem_owner == bus_agent))) |=> $stable(sel_word));

    // R6: a missing copy keeps its stored value across any access.
    for (genvar k = 0; k < N; k++) begin : g_absent
        a_r6_absent_stable: assert property (@(posedge clk) disable iff (rst)
            !present_mask[k] |=> $stable(store_flat[k*DW +: DW]));
    end

endmodule

bind replicated_steer_unit steer_chk #(
    .N    (N),
    .DW   (DW),
    .IDXW (IDXW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_re       (bus_re),
    .bus_we       (bus_we),
    .bus_agent    (bus_agent),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .present_mask (present_mask),
    .space        (space),
    .sel_word     (sel_word),
    .sem_held     (sem_held),
    .sem_owner    (sem_owner),
    .rep_idx      (rep_idx),
    .store_flat   (store_flat)
);

// File: tb/replicated_steer_unit_tb.sv
`timescale 1ns/100ps
module replicated_steer_unit_tb;
    localparam int G  = 2;
    localparam int I  = 4;
    localparam int N  = G * I;
    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_agent = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_re = 1'b0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [N-1:0]  present_mask = '1;
    logic [DW-1:0] bus_rdata;

    int checks = 0;
    int fails  = 0;

    // Behavioural reference state.
    logic [31:0] m_store [N];
    bit          m_bc;
    int          m_g, m_i;
    bit          m_held, m_owner;

    always #2.5 clk = ~clk;

    replicated_steer_unit #(.GROUPS(G), .INSTS(I), .DW(DW), .AW(AW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_agent    (bus_agent),
        .bus_addr     (bus_addr),
        .bus_re       (bus_re),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .present_mask (present_mask),
        .bus_rdata    (bus_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input bit ag, input int a);
        int idx;
        case (a)
            0: return {m_bc, 15'd0, 8'(m_g), 8'(m_i)};
            1: begin
                idx = m_g * I + m_i;
                return present_mask[idx] ? m_store[idx] : 32'd0;
            end
            2: return (!m_held || m_owner == ag) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_after_read(input bit ag, input int a);
        if (a == 2 && !m_held) begin
            m_held  = 1'b1;
            m_owner = ag;
        end
    endtask

    task automatic model_write(input bit ag, input int a, input logic [31:0] d);
        int idx;
        case (a)
            0: if (m_held && m_owner == ag) begin
                m_bc = d[31];
                m_g  = int'(d[15:8]) % G;
                m_i  = int'(d[7:0]) % I;
            end
            1: begin
                if (m_bc) begin
                    for (int k = 0; k < N; k++) if (present_mask[k]) m_store[k] = d;
                end else begin
                    idx = m_g * I + m_i;
                    if (present_mask[idx]) m_store[idx] = d;
                end
            end
            2: if (d[0] && m_held && m_owner == ag) m_held = 1'b0;
            default: ;
        endcase
    endtask

    task automatic wr(input bit ag, input int a, input logic [31:0] d);
        @(negedge clk);
        bus_agent = ag; bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
        @(posedge clk);
        model_write(ag, a, d);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input bit ag, input int a, input string tag);
        @(negedge clk);
        bus_agent = ag; bus_addr = AW'(a); bus_re = 1'b1; bus_we = 1'b0;
        #1 chk(tag, bus_rdata, model_read(ag, a));
        @(posedge clk);
        model_after_read(ag, a);
        #1 bus_re = 1'b0;
    endtask

    // Reads every copy through the selector, with the broadcast flag as given.
    task automatic sweep(input bit ag, input bit bc, input string tag);
        for (int g = 0; g < G; g++) begin
            for (int i = 0; i < I; i++) begin
                wr(ag, 0, {bc, 15'd0, 8'(g), 8'(i)});
                rd(ag, 1, tag);
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) m_store[k] = '0;
        m_bc = 1'b1; m_g = 0; m_i = 0; m_held = 1'b0; m_owner = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R7 reset selector word and copies
        rd(0, 0, "R1_reset_selector");
        chk("R1_reset_value", model_read(0, 0), 32'h8000_0000);
        rd(1, 1, "R1_reset_copy");
        // R11 read strobe low gives zero
        @(negedge clk); bus_addr = AW'(0); #1 chk("R11_idle_zero", bus_rdata, 32'd0);

        // R10 selector write while free is ignored
        wr(1, 0, 32'h0000_0102);
        rd(1, 0, "R10_unheld_write_ignored");

        // R8 acquire by agent 0, agent 1 locked out
        rd(0, 2, "R8_acquire");
        rd(1, 2, "R8_contend_zero");
        rd(0, 2, "R8_owner_reread");
        wr(1, 0, 32'h0000_0103);
        rd(0, 0, "R10_non_owner_write");

        // R2 broadcast with all present
        wr(0, 1, 32'hA5A5_0001);
        sweep(0, 1'b1, "R2_R4_broadcast_all");

        // R6 broadcast with holes, then sweep with holes and after restoring
        present_mask = 8'b1101_0110;
        wr(0, 0, 32'h8000_0000);
        wr(0, 1, 32'h5A5A_0002);
        sweep(0, 1'b1, "R5_holes_read_zero");
        present_mask = '1;
        sweep(0, 1'b0, "R6_broadcast_skip");

        // R3 unicast writes, R7 oversized field bits dropped
        wr(0, 0, 32'h0000_FF07);
        rd(0, 0, "R7_field_mask");
        wr(0, 1, 32'h1234_5678);
        wr(0, 0, 32'h0000_0002);
        wr(0, 1, 32'hCAFE_0003);
        sweep(0, 1'b0, "R3_unicast_only");
        sweep(0, 1'b1, "R4_read_with_broadcast");

        // R6 unicast to missing copy dropped
        present_mask = 8'b1111_1011;
        wr(0, 0, 32'h0000_0002);
        rd(0, 1, "R5_absent_zero");
        wr(0, 1, 32'hDEAD_BEEF);
        present_mask = '1;
        rd(0, 1, "R6_unicast_dropped");

        // R9 release rules
        wr(1, 2, 32'd1);
        rd(1, 2, "R9_non_owner_release_ignored");
        wr(0, 2, 32'd0);
        rd(1, 2, "R9_zero_release_ignored");
        wr(0, 2, 32'd1);
        rd(1, 2, "R9_handover");
        rd(0, 2, "R9_old_owner_locked");
        wr(0, 0, 32'h0000_0001);
        rd(1, 0, "R10_old_owner_write");
        wr(1, 0, 32'h0000_0101);
        rd(1, 0, "R10_new_owner_write");

        // R11 unmapped addresses
        rd(0, 3, "R11_unmapped");
        rd(1, 15, "R11_unmapped_top");

        // Mixed random traffic from both agents
        for (int n = 0; n < 400; n++) begin
            int op;
            bit ag;
            op = int'($urandom_range(0, 9));
            ag = 1'($urandom_range(0, 1));
            if (op == 0) present_mask = N'($urandom);
            else if (op == 1) wr(ag, 0, {1'($urandom_range(0, 1)), 15'd0, 8'($urandom), 8'($urandom)});
            else if (op == 2) wr(ag, 1, $urandom);
            else if (op == 3) wr(ag, 2, 32'($urandom_range(0, 1)));
            else if (op == 4) rd(ag, 2, "R8_R9_random_sem");
            else if (op == 5) rd(ag, 0, "R7_R10_random_sel");
            else if (op == 6) rd(ag, int'($urandom_range(3, 15)), "R11_random_unmapped");
            else rd(ag, 1, "R2_R3_R4_R5_random_copy");
        end

        // Final full readback
        present_mask = '1;
        if (m_held) wr(m_owner, 2, 32'd1);
        rd(0, 2, "R8_final_acquire");
        sweep(0, 1'b0, "R6_final_readback");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule